// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Comparator

This block keeps two alarm register sets, called alarm A and alarm B. On every once-per-second time update it compares each set against the live time. Every alarm field carries a mask bit, and the combination of mask bits sets how often the alarm repeats: every second, every minute, or on a match of a growing set of fields. The day/date alarm field carries a select bit. That bit chooses whether the alarm compares against the day of the week or the date of the month. Alarm B has no seconds field. It can only fire when the seconds count is zero.

A match sets a sticky flag for that alarm. The flag is set whatever the interrupt settings are. Software clears it by writing a 0 to its bit. An active-low interrupt output combines the flags with two per-alarm enables and an interrupt-mode bit. Software reaches the registers through a byte write port and a combinational read port. The time counters feed in the current seconds, minutes, hours, weekday and date, plus a one-cycle strobe for each update.

Internally a two-state machine runs the compare. ST_IDLE waits for the strobe. The transition on the strobe captures the time and moves to ST_EVAL. In ST_EVAL the captured time is compared and the flags are updated. It then returns to ST_IDLE, or stays in ST_EVAL if another strobe arrives.

Top module: `alm_cmp`

## Requirements
- R1: After reset the control register (address 7) reads 0x04: interrupt mode on, both enables off. The flag register (address 8) reads 0x00, every alarm register reads 0x00, and irq_n is 1.
- R2: The register addresses are: 0 to 3 for alarm A seconds, minutes, hours and day/date; 4 to 6 for alarm B minutes, hours and day/date; 7 for control; 8 for flags. Alarm registers read back what was written. Control bit 0 enables alarm A, bit 1 enables alarm B, bit 2 is the interrupt mode, and its other bits read 0. Flag bit 0 belongs to A and bit 1 to B. Unmapped addresses read 0 and ignore writes.
- R3: The comparison happens only on a strobe. The time is captured at the clock edge where sec_tick is high, and the flag is set at the following edge. A matching time without a strobe sets nothing.
- R4: Bit 7 of each alarm A field masks that field. The mask patterns (day, hours, minutes, seconds) are: 1111 fires every second; 1110 fires on a seconds match; 1100 fires on a minutes and seconds match; 1000 adds hours; 0000 adds day/date.
- R5: Bit 7 of each alarm B field masks that field, and the seconds count must be 00. The patterns (day, hours, minutes) are: 111 fires once per minute; 110 fires on a minutes match; 100 adds hours; 000 adds day/date.
- R6: In the day/date fields, bit 6 = 0 compares bits 5:0 with the date of the month, and bit 6 = 1 compares them with the day of the week.
- R7: Hours compare bits 6:0 in full, including the 12/24 bit (bit 6) and the AM/PM bit (bit 5).
- R8: A mask pattern that is not listed in R4 or R5 (a masked field below an unmasked one) never sets the flag. The block keeps working once a listed pattern is restored.
- R9: Flags are sticky. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. A match in the same cycle as a clear write leaves the flag set.
- R10: A match sets its flag whatever the state of the interrupt mode and the enables.
- R11: irq_n is 0 exactly when the mode bit is 1 and some flag is set together with its enable. With the mode bit at 0, irq_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Read data (combinational) |
| sec_tick | input | 1 | One-cycle strobe for each once-per-second update |
| now_sec | input | DW-1 | Current seconds |
| now_min | input | DW-1 | Current minutes |
| now_hour | input | DW-1 | Current hours with 12/24 and AM/PM bits |
| now_wday | input | DW-1 | Current day of the week |
| now_mday | input | DW-1 | Current date of the month |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its default parameters: byte-wide registers and a 4-bit address. At this size every mask pattern of both alarms, and the unmapped address space, can be driven directly. The bench walks each listed repeat rate of both alarms, flipping a single compared field between a match and a miss. It also drives unlisted mask patterns with fully matching times, and checks a clear write that lands in the same cycle as a match. The interrupt output is checked across every combination of mode, enables and flags that matters.

// File: rtl/alm_cmp_pkg.sv
package alm_cmp_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } alm_state_e;

    localparam int NUM_ALM  = 2;
    localparam int NUM_FLD  = 4;
    localparam int NUM_TOD  = 3;   // seconds, minutes, hours

    localparam int AD_A_SEC  = 0;
    localparam int AD_A_MIN  = 1;
    localparam int AD_A_HOUR = 2;
    localparam int AD_A_DAY  = 3;
    localparam int AD_B_MIN  = 4;
    localparam int AD_B_HOUR = 5;
    localparam int AD_B_DAY  = 6;
    localparam int AD_CTRL   = 7;
    localparam int AD_FLAG   = 8;

    localparam int CB_EN_A = 0;
    localparam int CB_EN_B = 1;
    localparam int CB_MODE = 2;
    localparam int CTRL_W  = 3;
endpackage

// File: rtl/alm_field_match.sv
module alm_field_match #(
    parameter int TW = 7
) (
    input  logic          mask,
    input  logic [TW-1:0] want,
    input  logic [TW-1:0] have,
    output logic          ok
);
    assign ok = mask | (want == have);
endmodule

// File: rtl/alm_unit.sv
module alm_unit
    import alm_cmp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [NUM_FLD-1:0][DW-1:0] fld,
    input  logic [DW-2:0]              t_sec,
    input  logic [DW-2:0]              t_min,
    input  logic [DW-2:0]              t_hour,
    input  logic [DW-2:0]              t_wday,
    input  logic [DW-2:0]              t_mday,
    output logic                       hit
);
    localparam int TW = DW - 1;

    logic [NUM_FLD-1:0]         msk;
    logic [NUM_FLD-1:0]         ok;
    logic [NUM_TOD-1:0][TW-1:0] tod;
    logic [TW-1:0]              dd_have;
    logic [TW-1:0]              dd_want;
    logic                       legal;

    assign tod = {t_hour, t_min, t_sec};

    for (genvar f = 0; f < NUM_FLD; f++) begin : g_msk
        assign msk[f] = fld[f][DW-1];
    end

    for (genvar f = 0; f < NUM_TOD; f++) begin : g_tod
        alm_field_match #(.TW(TW)) u_fm (
            .mask (msk[f]),
            .want (fld[f][TW-1:0]),
            .have (tod[f]),
            .ok   (ok[f])
        );
    end

    // bit DW-2 selects weekday (1) or date (0); low bits hold the value
    assign dd_have = fld[NUM_FLD-1][DW-2] ? t_wday : t_mday;
    assign dd_want = {1'b0, fld[NUM_FLD-1][DW-3:0]};

    alm_field_match #(.TW(TW)) u_fm_dd (
        .mask (msk[NUM_FLD-1]),
        .want (dd_want),
        .have (dd_have),
        .ok   (ok[NUM_FLD-1])
    );

    // listed patterns: a masked field implies every higher field masked
    assign legal = &(~msk[NUM_FLD-2:0] | msk[NUM_FLD-1:1]);
    assign hit   = legal & (&ok);
endmodule

// File: rtl/alm_cmp.sv
module alm_cmp
    import alm_cmp_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          sec_tick,
    input  logic [DW-2:0] now_sec,
    input  logic [DW-2:0] now_min,
    input  logic [DW-2:0] now_hour,
    input  logic [DW-2:0] now_wday,
    input  logic [DW-2:0] now_mday,
    output logic          irq_n
);
    localparam int TW = DW - 1;

    alm_state_e state_q, state_d;

    logic [NUM_FLD-1:0][DW-1:0]   reg_a;
    logic [NUM_FLD-2:0][DW-1:0]   reg_b;
    logic [CTRL_W-1:0]            ctrl_q;
    logic [NUM_ALM-1:0]           flag_q, flag_d;
    logic [NUM_ALM-1:0]           hit;
    logic [TW-1:0] snap_sec, snap_min, snap_hour, snap_wday, snap_mday;
    logic [NUM_ALM-1:0][NUM_FLD-1:0][DW-1:0] fld_all;

    // alarm B: seconds slot fixed at 00, unmasked
    assign fld_all[0] = reg_a;
    assign fld_all[1] = {reg_b, {DW{1'b0}}};

    for (genvar gi = 0; gi < NUM_ALM; gi++) begin : g_alm
        alm_unit #(.DW(DW)) u_unit (
            .fld    (fld_all[gi]),
            .t_sec  (snap_sec),
            .t_min  (snap_min),
            .t_hour (snap_hour),
            .t_wday (snap_wday),
            .t_mday (snap_mday),
            .hit    (hit[gi])
        );
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (sec_tick) state_d = ST_EVAL;
            ST_EVAL: state_d = sec_tick ? ST_EVAL : ST_IDLE;
        endcase
    end

    // time capture on the strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_sec  <= '0;
            snap_min  <= '0;
            snap_hour <= '0;
            snap_wday <= '0;
            snap_mday <= '0;
        end else if (sec_tick) begin
            snap_sec  <= now_sec;
            snap_min  <= now_min;
            snap_hour <= now_hour;
            snap_wday <= now_wday;
            snap_mday <= now_mday;
        end
    end

    // flag next value: clear by writing 0, set wins
    always_comb begin
        flag_d = flag_q;
        if (wr_en && wr_addr == AW'(AD_FLAG))
            flag_d = flag_q & wr_data[NUM_ALM-1:0];
        if (state_q == ST_EVAL)
            flag_d = flag_d | hit;
    end

    // register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_a  <= '0;
            reg_b  <= '0;
            ctrl_q <= CTRL_W'(1 << CB_MODE);
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
            if (wr_en) begin
                case (wr_addr)
                    AW'(AD_A_SEC):  reg_a[0] <= wr_data;
                    AW'(AD_A_MIN):  reg_a[1] <= wr_data;
                    AW'(AD_A_HOUR): reg_a[2] <= wr_data;
                    AW'(AD_A_DAY):  reg_a[3] <= wr_data;
                    AW'(AD_B_MIN):  reg_b[0] <= wr_data;
                    AW'(AD_B_HOUR): reg_b[1] <= wr_data;
                    AW'(AD_B_DAY):  reg_b[2] <= wr_data;
                    AW'(AD_CTRL):   ctrl_q   <= wr_data[CTRL_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        irq_n = ~(ctrl_q[CB_MODE] &
                  ((flag_q[0] & ctrl_q[CB_EN_A]) | (flag_q[1] & ctrl_q[CB_EN_B])));
        case (rd_addr)
            AW'(AD_A_SEC):  rd_data = reg_a[0];
            AW'(AD_A_MIN):  rd_data = reg_a[1];
            AW'(AD_A_HOUR): rd_data = reg_a[2];
            AW'(AD_A_DAY):  rd_data = reg_a[3];
            AW'(AD_B_MIN):  rd_data = reg_b[0];
            AW'(AD_B_HOUR): rd_data = reg_b[1];
            AW'(AD_B_DAY):  rd_data = reg_b[2];
            AW'(AD_CTRL):   rd_data = {{(DW-CTRL_W){1'b0}}, ctrl_q};
            AW'(AD_FLAG):   rd_data = {{(DW-NUM_ALM){1'b0}}, flag_q};
            default:        rd_data = '0;
        endcase
    end

    // R9: a set flag survives anything but a 0 written to its bit
    a_r9_flag_a_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[0] && !(wr_en && wr_addr == AW'(AD_FLAG) && !wr_data[0])) |=> flag_q[0]);

    // R3: flags only rise right after an evaluation cycle
    a_r3_rise_after_eval: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[1]) |-> $past(state_q == ST_EVAL));

    // R3: evaluation lasts one cycle unless another strobe arrives
    a_r3_eval_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL && !sec_tick) |=> (state_q == ST_IDLE));

    // R5: alarm B only fires on second 00
    a_r5_b_zero_sec: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[1]) |-> (snap_sec == '0));

    // R11: interrupt needs a flag and the mode bit
    a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> ((flag_q != '0) && ctrl_q[CB_MODE]));
endmodule

// File: tb/alm_cmp_test.sv
module alm_cmp_test;
    localparam int DW = 8;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          sec_tick = 1'b0;
    logic [DW-2:0] now_sec = '0, now_min = '0, now_hour = '0, now_wday = '0, now_mday = '0;
    logic          irq_n;

    always #4 clk = ~clk;

    alm_cmp #(.DW(DW), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sec_tick(sec_tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_wday(now_wday), .now_mday(now_mday), .irq_n(irq_n)
    );

    typedef struct {
        string        req;
        bit           is_irq;
        logic [DW-1:0] exp;
    } exp_t;

    exp_t q[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            wait (q.size() != 0);
            begin
                exp_t it;
                logic [DW-1:0] act;
                it = q.pop_front();
                act = it.is_irq ? {{(DW-1){1'b0}}, irq_n} : rd_data;
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s act=%h exp=%h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic exp_reg(input string req, input int addr, input logic [DW-1:0] e);
        exp_t it;
        rd_addr = AW'(addr);
        #1;
        it.req = req; it.is_irq = 0; it.exp = e;
        q.push_back(it);
        #0;
    endtask

    task automatic exp_irq(input string req, input logic e);
        exp_t it;
        #1;
        it.req = req; it.is_irq = 1; it.exp = {{(DW-1){1'b0}}, e};
        q.push_back(it);
        #0;
    endtask

    task automatic wr(input int addr, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(input logic [6:0] s, input logic [6:0] m, input logic [6:0] h,
                        input logic [6:0] wd, input logic [6:0] md);
        @(negedge clk);
        now_sec = s; now_min = m; now_hour = h; now_wday = wd; now_mday = md;
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        @(negedge clk);
    endtask

    // watchdog
    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        exp_reg("R1 ctrl", 7, 8'h04);
        exp_reg("R1 flags", 8, 8'h00);
        exp_reg("R1 alarm reg", 0, 8'h00);
        exp_irq("R1 irq_n", 1'b1);

        // R2 register map
        wr(2, 8'h72);
        exp_reg("R2 readback", 2, 8'h72);
        wr(7, 8'hFF);
        exp_reg("R2 ctrl width", 7, 8'h07);
        wr(15, 8'h5A);
        exp_reg("R2 unmapped", 15, 8'h00);
        wr(7, 8'h04);
        wr(4, 8'h80);   // alarm B unlisted pattern: silent for now
        wr(5, 8'h00);
        wr(6, 8'h00);

        // R3 evaluation only on the strobe
        wr(0, 8'h30); wr(1, 8'h80); wr(2, 8'h80); wr(3, 8'h80);
        @(negedge clk);
        now_sec = 7'h30;
        repeat (3) @(negedge clk);
        exp_reg("R3 no strobe", 8, 8'h00);
        tick(7'h31, 7'h05, 7'h01, 7'h1, 7'h01);
        exp_reg("R3 seconds miss", 8, 8'h00);
        tick(7'h30, 7'h05, 7'h01, 7'h1, 7'h01);
        exp_reg("R3 R4 seconds match", 8, 8'h01);
        exp_irq("R10 flag without enable irq_n", 1'b1);

        // R9 write 1 keeps, write 0 clears
        wr(8, 8'h03);
        exp_reg("R9 write one", 8, 8'h01);
        wr(8, 8'h00);
        exp_reg("R9 write zero", 8, 8'h00);

        // R4 every second
        wr(0, 8'h80);
        tick(7'h17, 7'h05, 7'h01, 7'h1, 7'h01);
        exp_reg("R4 every second", 8, 8'h01);
        wr(8, 8'h00);

        // R4 minutes and seconds
        wr(0, 8'h15); wr(1, 8'h42);
        tick(7'h15, 7'h41, 7'h01, 7'h1, 7'h01);
        exp_reg("R4 min miss", 8, 8'h00);
        tick(7'h15, 7'h42, 7'h01, 7'h1, 7'h01);
        exp_reg("R4 min match", 8, 8'h01);
        wr(8, 8'h00);

        // R4 hours
        wr(2, 8'h09);
        tick(7'h15, 7'h42, 7'h10, 7'h1, 7'h01);
        exp_reg("R4 hour miss", 8, 8'h00);
        tick(7'h15, 7'h42, 7'h09, 7'h1, 7'h01);
        exp_reg("R4 hour match", 8, 8'h01);
        wr(8, 8'h00);

        // R7 AM/PM is compared
        wr(2, 8'h49);
        tick(7'h15, 7'h42, 7'h69, 7'h1, 7'h01);
        exp_reg("R7 pm vs am", 8, 8'h00);
        tick(7'h15, 7'h42, 7'h49, 7'h1, 7'h01);
        exp_reg("R7 am match", 8, 8'h01);
        wr(8, 8'h00);

        // R6 date then weekday
        wr(3, 8'h15);
        tick(7'h15, 7'h42, 7'h49, 7'h3, 7'h15);
        exp_reg("R6 date match", 8, 8'h01);
        wr(8, 8'h00);
        tick(7'h15, 7'h42, 7'h49, 7'h3, 7'h16);
        exp_reg("R6 date miss", 8, 8'h00);
        wr(3, 8'h43);
        tick(7'h15, 7'h42, 7'h49, 7'h3, 7'h16);
        exp_reg("R6 weekday match", 8, 8'h01);
        wr(8, 8'h00);
        tick(7'h15, 7'h42, 7'h49, 7'h4, 7'h03);
        exp_reg("R6 weekday miss", 8, 8'h00);

        // R8 unlisted pattern on A
        wr(1, 8'hC2);
        tick(7'h15, 7'h42, 7'h49, 7'h3, 7'h16);
        exp_reg("R8 A unlisted", 8, 8'h00);
        wr(1, 8'h42);
        tick(7'h15, 7'h42, 7'h49, 7'h3, 7'h16);
        exp_reg("R8 A recovers", 8, 8'h01);
        wr(8, 8'h00);

        // R5 alarm B (A silenced by an unlisted pattern)
        wr(0, 8'h80);
        wr(4, 8'h80); wr(5, 8'h80); wr(6, 8'h80);
        tick(7'h05, 7'h33, 7'h01, 7'h1, 7'h01);
        exp_reg("R5 B nonzero sec", 8, 8'h00);
        tick(7'h00, 7'h33, 7'h01, 7'h1, 7'h01);
        exp_reg("R5 B per minute", 8, 8'h02);
        wr(8, 8'h00);
        wr(4, 8'h20);
        tick(7'h00, 7'h20, 7'h01, 7'h1, 7'h01);
        exp_reg("R5 B minutes match", 8, 8'h02);
        wr(8, 8'h00);
        tick(7'h01, 7'h20, 7'h01, 7'h1, 7'h01);
        exp_reg("R5 B second 01", 8, 8'h00);

        // R8 unlisted pattern on B
        wr(4, 8'hA0); wr(5, 8'h00);
        tick(7'h00, 7'h20, 7'h00, 7'h1, 7'h01);
        exp_reg("R8 B unlisted", 8, 8'h00);

        // R10 mode off still sets flag
        wr(7, 8'h00);
        wr(4, 8'h80); wr(5, 8'h80);
        tick(7'h00, 7'h11, 7'h01, 7'h1, 7'h01);
        exp_reg("R10 flag with mode off", 8, 8'h02);
        exp_irq("R11 mode off irq_n", 1'b1);

        // R11 gating
        wr(7, 8'h06);
        exp_irq("R11 B enabled", 1'b0);
        wr(7, 8'h02);
        exp_irq("R11 mode off", 1'b1);
        wr(7, 8'h05);
        exp_irq("R11 other enable", 1'b1);
        wr(7, 8'h07);
        exp_irq("R11 both enabled", 1'b0);
        wr(8, 8'h00);
        exp_irq("R11 cleared", 1'b1);

        // R9 set wins over a clear in the same cycle
        @(negedge clk);
        now_sec = 7'h00; sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        wr_en = 1'b1; wr_addr = AW'(8); wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        exp_reg("R9 set wins", 8, 8'h02);
        exp_irq("R11 irq after set", 1'b0);

        @(negedge clk);
        wait (q.size() == 0);
        #1;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule